// File: doc/BRIEF.md
# Serial Control Port with Sticky Fault Readout

This block is the serial control port of a power-driver channel. A host drives chip select, serial clock and serial data into it. The host uses it to write a configuration word and to read back fault status. Each frame is 16 bits per device. Devices can be chained by passing the serial output of one into the serial input of the next, and a chained frame is then a whole multiple of 16 bits. The last 16 bits received before chip select goes high are this device's command.

The reply to a command comes out during the following frame. After power-on reset the first reply is a fixed identifier word. After that, every reply is a fault word: one live enable bit plus fault flags that are held until they are read. While chip select is low and no clock edge has yet arrived, the serial output shows one fast status bit. This bit lets the host see at once whether any fault is latched. The serial pins are brought into the core clock domain through synchronizers and sampled by an internal clock that is much faster than the serial clock.

Top module: `drv_spi_slave`

## Requirements
- R1: A frame is valid when its number of serial clock falling edges is a non-zero multiple of 16. The command is the last 16 bits received. From the 17th rising edge onward, `sdo_o` repeats `sdi_i` delayed by 16 bits.
- R2: The reply sent during a frame belongs to the last valid frame before it. A diagnosis read issued in frame N is answered, and its flags released, in frame N+1.
- R3: Until the first valid frame after reset ends, the reply word is ID_WORD (default 16'hC95A).
- R4: Data is MSB first. `sdo_o` moves to the next bit after each rising serial clock edge, and `sdi_i` is taken on each falling edge.
- R5: `sdo_oe_o` is low whenever `cs_ni` is high or `rst_ni` is low, and high otherwise.
- R6: Command bits [15:14] = 2'b01 load bits [13:0] into `cfg_o`, and only when chip select rises at the end of a valid frame. The other codes leave `cfg_o` unchanged. `cfg_o` resets to zero.
- R7: From the fall of `cs_ni` until the first rising serial clock edge, `sdo_o` equals the OR of all latched fault flags. No serial clock is needed for this.
- R8: The fault word has bit 15 = live `en_i` (not latched), bits [NF-1:0] = latched flags, and all other bits zero. It is sampled when chip select falls.
- R9: A single-cycle pulse on `fault_i[k]` sets flag k, and the flag stays set. Flags are cleared only at the end of a valid frame that follows a read command (bits [15:14] = 2'b10). Only the flags carried in that frame's reply are cleared, and a fault arriving in the same cycle still sets its flag.
- R10: An invalid frame leaves `cfg_o` unchanged, clears no flag, and does not advance the reply sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock that oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock, idle low |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o (high = drive) |
| fault_i | input | NF | Fault event inputs, one per flag |
| en_i | input | 1 | Live enable status |
| cfg_o | output | 14 | Applied configuration word |

## Verification
The assertions assume the serial clock is low whenever chip select changes. They also assume each serial clock level lasts longer than the synchronizer delay plus one core cycle, so that no rising edge, falling edge or chip select edge is seen in the same core cycle as another. The stimulus holds each serial clock half period for eight core cycles and changes `sdi_i` only together with a rising serial clock edge. It always leaves one half period between a chip select edge and the nearest serial clock edge.

// File: rtl/drv_spi_pkg.sv
package drv_spi_pkg;
  localparam int FRAME_W = 16;
  localparam int CFG_W   = FRAME_W - 2;

  typedef enum logic [1:0] {
    CMD_NOP     = 2'b00,
    CMD_WR_CFG  = 2'b01,
    CMD_RD_DIAG = 2'b10,
    CMD_RSVD    = 2'b11
  } cmd_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int           W       = 3,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {STAGES{RST_VAL}};
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
  import drv_spi_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_ns_i,
  input  logic               sck_s_i,
  input  logic               sdi_s_i,
  input  logic [FRAME_W-1:0] load_word_i,
  input  logic               fast_bit_i,
  output logic               sdo_o,
  output logic               frame_start_o,
  output logic               frame_end_o,
  output logic               frame_ok_o,
  output logic [FRAME_W-1:0] rx_word_o
);
  localparam int CNT_W = $clog2(FRAME_W);

  logic               cs_d_q, sck_d_q;
  logic [FRAME_W-1:0] sr_q;
  logic               so_q, rise_seen_q, any_q;
  logic [CNT_W-1:0]   cnt_q;

  wire sck_rise = sck_s_i & ~sck_d_q & ~cs_ns_i;
  wire sck_fall = ~sck_s_i & sck_d_q & ~cs_ns_i;
  assign frame_start_o = cs_d_q & ~cs_ns_i;
  assign frame_end_o   = ~cs_d_q & cs_ns_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_d_q      <= 1'b1;
      sck_d_q     <= 1'b0;
      sr_q        <= '0;
      so_q        <= 1'b0;
      rise_seen_q <= 1'b0;
      any_q       <= 1'b0;
      cnt_q       <= '0;
    end else begin
      cs_d_q  <= cs_ns_i;
      sck_d_q <= sck_s_i;
      if (frame_start_o) begin
        sr_q  <= load_word_i;
        cnt_q <= '0;
        any_q <= 1'b0;
      end else if (sck_fall) begin
        sr_q  <= {sr_q[FRAME_W-2:0], sdi_s_i};
        cnt_q <= cnt_q + 1'b1;
        any_q <= 1'b1;
      end
      if (sck_rise) so_q <= sr_q[FRAME_W-1];
      if (cs_ns_i)       rise_seen_q <= 1'b0;
      else if (sck_rise) rise_seen_q <= 1'b1;
    end
  end

  // before the first rising edge the fast status bit owns the pin
  assign sdo_o      = rise_seen_q ? so_q : fast_bit_i;
  assign frame_ok_o = any_q && (cnt_q == '0);
  assign rx_word_o  = sr_q;

  // R4
  rise_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_seen_q && !cs_ns_i) |=> rise_seen_q);
endmodule

// File: rtl/diag_flag_latch.sv
module diag_flag_latch #(
  parameter int NF = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NF-1:0] fault_i,
  input  logic          clr_i,
  input  logic [NF-1:0] clr_mask_i,
  output logic [NF-1:0] flags_o
);
  logic [NF-1:0] flags_q, clr_eff;

  assign clr_eff = clr_i ? clr_mask_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~clr_eff) | fault_i;
  end

  assign flags_o = flags_q;

  // R9
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((($past(flags_q) & ~$past(clr_eff)) & ~flags_q) == '0));
  // R9
  fault_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|fault_i) |=> ((flags_q & $past(fault_i)) == $past(fault_i)));
endmodule

// File: rtl/drv_spi_slave.sv
module drv_spi_slave
  import drv_spi_pkg::*;
#(
  parameter int                 NF          = 8,
  parameter logic [FRAME_W-1:0] ID_WORD     = 16'hC95A,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sck_i,
  input  logic             sdi_i,
  output logic             sdo_o,
  output logic             sdo_oe_o,
  input  logic [NF-1:0]    fault_i,
  input  logic             en_i,
  output logic [CFG_W-1:0] cfg_o
);
  localparam int PAD_W = FRAME_W - 1 - NF;

  logic [2:0]         pins_s;
  logic               frame_start, frame_end, frame_ok;
  logic [FRAME_W-1:0] rx_word, reply;
  logic [NF-1:0]      flags, sent_q;
  logic               id_pend_q, rd_pend_q, clr_arm_q;
  logic [CFG_W-1:0]   cfg_q;
  cmd_e               cmd;

  spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({cs_ni, sck_i, sdi_i}),
    .q_o (pins_s)
  );

  assign reply = id_pend_q ? ID_WORD : {en_i, {PAD_W{1'b0}}, flags};

  spi_frame_shifter u_shift (
    .clk_i, .rst_ni,
    .cs_ns_i       (pins_s[2]),
    .sck_s_i       (pins_s[1]),
    .sdi_s_i       (pins_s[0]),
    .load_word_i   (reply),
    .fast_bit_i    (|flags),
    .sdo_o         (sdo_o),
    .frame_start_o (frame_start),
    .frame_end_o   (frame_end),
    .frame_ok_o    (frame_ok),
    .rx_word_o     (rx_word)
  );

  wire commit = frame_end & frame_ok;
  assign cmd = cmd_e'(rx_word[FRAME_W-1 -: 2]);

  diag_flag_latch #(.NF(NF)) u_diag (
    .clk_i, .rst_ni,
    .fault_i    (fault_i),
    .clr_i      (commit & clr_arm_q),
    .clr_mask_i (sent_q),
    .flags_o    (flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      id_pend_q <= 1'b1;
      rd_pend_q <= 1'b0;
      clr_arm_q <= 1'b0;
      sent_q    <= '0;
      cfg_q     <= '0;
    end else begin
      if (frame_start) begin
        clr_arm_q <= rd_pend_q;
        sent_q    <= flags;
      end
      if (commit) begin
        id_pend_q <= 1'b0;
        rd_pend_q <= (cmd == CMD_RD_DIAG);
        if (cmd == CMD_WR_CFG) cfg_q <= rx_word[CFG_W-1:0];
      end
    end
  end

  assign cfg_o    = cfg_q;
  assign sdo_oe_o = rst_ni & ~cs_ni;

  // R6
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(cfg_q));
endmodule

// File: tb/drv_spi_slave_bench.sv
module drv_spi_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NF         = 8;

  typedef struct packed {
    logic [15:0] tx;
    logic [13:0] cfg;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{16'h4ABC, 14'h0ABC},
    '{16'h0FFF, 14'h0ABC},
    '{16'hC123, 14'h0ABC},
    '{16'h7555, 14'h3555},
    '{16'h4000, 14'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b0, sdi = 1'b0, en = 1'b0;
  logic [NF-1:0] fault = '0;
  logic sdo, sdo_oe;
  logic [13:0] cfg;
  int n_chk = 0, n_fail = 0;
  logic [63:0] dout;
  logic fast;

  always #(CLK_PERIOD/2) clk = ~clk;

  drv_spi_slave u_drv_spi_slave (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe), .fault_i(fault), .en_i(en), .cfg_o(cfg)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic frame_body(input int nbits, input logic [63:0] din);
    @(negedge clk); cs_n = 1'b0;
    @(negedge clk); fast = sdo;
    chk(sdo_oe == 1'b1, "R5 oe while selected", 64'(sdo_oe), 64'd1);
    repeat (HALF) @(negedge clk);
    dout = '0;
    for (int i = 0; i < nbits; i++) begin
      sck = 1'b1; sdi = din[nbits-1-i];
      repeat (HALF) @(negedge clk);
      dout[nbits-1-i] = sdo;
      sck = 1'b0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic frame_close();
    cs_n = 1'b1;
    repeat (2*HALF) @(negedge clk);
  endtask

  task automatic frame(input int nbits, input logic [63:0] din);
    frame_body(nbits, din);
    frame_close();
  endtask

  task automatic pulse_fault(input logic [NF-1:0] f);
    @(negedge clk); fault = f;
    @(negedge clk); fault = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(sdo_oe == 1'b0, "R5 oe in reset", 64'(sdo_oe), 64'd0);
    chk(cfg == '0, "R6 cfg reset", 64'(cfg), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(sdo_oe == 1'b0, "R5 oe cs high", 64'(sdo_oe), 64'd0);

    // R3 R4: identifier, MSB first
    frame(16, 64'h0000);
    chk(dout[15:0] == 16'hC95A, "R3 R4 first reply id", 64'(dout[15:0]), 64'hC95A);
    chk(fast == 1'b0, "R7 fast bit no fault", 64'(fast), 64'd0);

    foreach (VECS[k]) begin
      frame(16, 64'(VECS[k].tx));
      chk(cfg == VECS[k].cfg, "R6 cfg vector", 64'(cfg), 64'(VECS[k].cfg));
      chk(dout[15:0] == 16'h0000, "R8 quiet reply", 64'(dout[15:0]), 64'h0);
    end

    // R8 enable is live, not latched
    en = 1'b1;
    frame(16, 64'h0000);
    chk(dout[15:0] == 16'h8000, "R8 enable bit", 64'(dout[15:0]), 64'h8000);
    en = 1'b0;
    frame(16, 64'h0000);
    chk(dout[15:0] == 16'h0000, "R8 enable not latched", 64'(dout[15:0]), 64'h0);

    // R7 R9 R2 sticky flag, cleared one frame after read
    pulse_fault(8'h04);
    frame(16, 64'h8000);
    chk(fast == 1'b1, "R7 fast bit fault", 64'(fast), 64'd1);
    chk(dout[15:0] == 16'h0004, "R9 flag sticky", 64'(dout[15:0]), 64'h0004);
    frame(16, 64'h0000);
    chk(dout[15:0] == 16'h0004, "R2 read answered next frame", 64'(dout[15:0]), 64'h0004);
    frame(16, 64'h0000);
    chk(dout[15:0] == 16'h0000, "R9 flag released", 64'(dout[15:0]), 64'h0);
    chk(fast == 1'b0, "R7 fast bit after clear", 64'(fast), 64'd0);

    // R10 invalid frame
    pulse_fault(8'h10);
    frame(16, 64'h8000);
    chk(dout[15:0] == 16'h0010, "R9 second flag", 64'(dout[15:0]), 64'h0010);
    frame(20, 64'h4FFF);
    chk(cfg == 14'h0000, "R10 cfg kept", 64'(cfg), 64'h0);
    frame(16, 64'h0000);
    chk(dout[15:0] == 16'h0010, "R10 flag not cleared", 64'(dout[15:0]), 64'h0010);
    frame(16, 64'h0000);
    chk(dout[15:0] == 16'h0000, "R10 cleared by valid frame", 64'(dout[15:0]), 64'h0);

    // R1 daisy chain
    frame(32, 64'hBEEF_4765);
    chk(dout[31:16] == 16'h0000, "R1 own reply", 64'(dout[31:16]), 64'h0);
    chk(dout[15:0] == 16'hBEEF, "R1 pass through", 64'(dout[15:0]), 64'hBEEF);
    chk(cfg == 14'h0765, "R1 last word command", 64'(cfg), 64'h0765);

    // R6 applied only at chip select rise
    frame_body(16, 64'h4222);
    chk(cfg == 14'h0765, "R6 cfg before cs rise", 64'(cfg), 64'h0765);
    frame_close();
    chk(cfg == 14'h0222, "R6 cfg after cs rise", 64'(cfg), 64'h0222);

    // R3 again after reset
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(cfg == '0, "R6 cfg cleared by reset", 64'(cfg), 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    frame(16, 64'h0000);
    chk(dout[15:0] == 16'hC95A, "R3 id after reset", 64'(dout[15:0]), 64'hC95A);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule